// File: doc/BRIEF.md
# Paired-Frame Translation Buffer with Per-Entry Page Size

This block is a fully associative address translation cache. It maps a 32-bit virtual address to a physical address of up to 36 bits. Every entry covers two adjacent virtual pages with a single tag and holds a separate physical frame for each page. One address bit picks between the two frames. Which bit it is depends on the entry's own page size, and that size can be any power of four from 1 KB to 256 MB. Matching is qualified by an address-space number, unless the entry is marked global.

Software loads entries through an indexed write port, and a write takes one cycle. A lookup presents the virtual address, the current address-space number, the access kind and a flag saying whether a translation exception is already being handled. The tag compare is combinational. One cycle later the block returns a registered response: either a translation (physical address plus cache attribute) or one exception code. If the contents are inconsistent and two or more entries match, the block raises a separate multi-match flag and returns no translation.

Top module: `pairTlb`

## Requirements
- R1: After reset no entry is in use. Every lookup then gives exception code 1 (refill), or code 4 when the handler flag is set.
- R2: The response registers capture a lookup one clock after `lkValid` is high, and `rspValid` goes high in that same cycle. When `rspValid` is low, `rspHit`, `rspExc`, `rspMultiHit`, `rspPa` and `rspCattr` are all zero.
- R3: An entry with size code c (0 to 9) has a page size of 1 KB * 4^c. Size codes 10 to 15 act as code 9. An entry matches when virtual address bits 31 down to 11+2c equal the same bits of its stored tag address. Tag bits below that position have no effect.
- R4: An entry whose global bit is 0 matches only if its address-space number equals `lkAsid`. With the global bit set to 1, any `lkAsid` matches.
- R5: Virtual address bit 10+2c selects frame 1 of the matching entry when it is 1 and frame 0 when it is 0.
- R6: On a hit, `rspPa` is the selected frame number shifted left by 10, except that its low 10+2c bits are taken from the virtual address. The low 2c bits of the written frame number are therefore ignored. `rspCattr` is the selected frame's attribute.
- R7: A lookup that matches no entry gives exception code 1 (refill).
- R8: A lookup that matches exactly one entry whose selected frame has its valid bit at 0 gives code 2 (invalid), for any access kind.
- R9: Access encoding is 0 = load, 1 = store, 2 = fetch. A store that hits a valid frame with its dirty bit at 0 gives code 3 (modified). A load or fetch to the same frame hits.
- R10: If the handler flag is set, codes 1, 2 and 3 are reported as code 4 (double fault). A hit is unaffected by the flag. Code 0 means no exception.
- R11: When two or more entries match, `rspMultiHit` is 1, `rspHit` is 0, `rspExc` is 0 and `rspPa` is 0.
- R12: A write replaces the whole entry at `wrIdx` after one clock edge. A write with `wrIdx` of `ENTRIES` or more changes nothing. A lookup in the same cycle as a write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 6 | Entry index to write |
| wrTag | input | VA_W | Virtual address of the page pair |
| wrSize | input | 4 | Page size code |
| wrGlobal | input | 1 | Entry ignores address-space number |
| wrAsid | input | ASID_W | Entry address-space number |
| wrPfn0 | input | PA_W-10 | Frame 0 number |
| wrCattr0 | input | CATTR_W | Frame 0 cache attribute |
| wrDirty0 | input | 1 | Frame 0 writable |
| wrValid0 | input | 1 | Frame 0 valid |
| wrPfn1 | input | PA_W-10 | Frame 1 number |
| wrCattr1 | input | CATTR_W | Frame 1 cache attribute |
| wrDirty1 | input | 1 | Frame 1 writable |
| wrValid1 | input | 1 | Frame 1 valid |
| lkValid | input | 1 | Lookup request |
| lkVa | input | VA_W | Virtual address to translate |
| lkAsid | input | ASID_W | Current address-space number |
| lkAccess | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lkInHandler | input | 1 | A translation exception is being handled |
| rspValid | output | 1 | Response for the previous cycle's lookup |
| rspHit | output | 1 | Translation returned |
| rspPa | output | PA_W | Physical address |
| rspCattr | output | CATTR_W | Cache attribute |
| rspExc | output | 3 | Exception code 0 to 4 |
| rspMultiHit | output | 1 | More than one entry matched |

## Verification
The assertions check the cycle-level rules of the response on every clock:
- the one-cycle timing of `rspValid`;
- zeroed outputs when idle;
- a hit, an exception and a multi-match never appear together;
- a double-fault code appears only with the handler flag set, and the normal codes never appear with it;
- a modified code comes only from a store;
- the page offset below 1 KB passes through unchanged.

Only the bench's scenarios, compared against its behavioural model, can show the following:
- that the right entry and frame are chosen for each page size, including the clamped codes;
- that address-space qualification works;
- that frame low bits are discarded;
- that out-of-range writes leave every entry untouched;
- that a write does not affect a lookup in the same cycle.

// File: rtl/pairTlbPkg.sv
package pairTlbPkg;
  localparam int MAX_IDX_W = 6;
  localparam int MIN_OFF   = 10;
  localparam int MAX_SIZE  = 9;

  typedef enum logic [2:0] {
    EXC_NONE     = 3'd0,
    EXC_REFILL   = 3'd1,
    EXC_INVALID  = 3'd2,
    EXC_MODIFIED = 3'd3,
    EXC_DOUBLE   = 3'd4
  } excCode_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } access_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic [MAX_IDX_W-1:0] wrIdx;
    logic                 latchXlate;
  } tlbStrobe_t;

  function automatic logic [3:0] clampSize(input logic [3:0] s);
    return (s > 4'(MAX_SIZE)) ? 4'(MAX_SIZE) : s;
  endfunction

  // ones in bit positions below MIN_OFF + 2*c + extra
  function automatic logic [63:0] lowMask(input logic [3:0] c, input int extra);
    int sh;
    sh = MIN_OFF + 2 * int'(c) + extra;
    return (64'd1 << sh) - 64'd1;
  endfunction
endpackage

// File: rtl/tlbData.sv
module tlbData
  import pairTlbPkg::*;
#(
  parameter int ENTRIES = 12,
  parameter int VA_W    = 32,
  parameter int PA_W    = 36,
  parameter int ASID_W  = 8,
  parameter int CATTR_W = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tlbStrobe_t                    strobe,
  input  logic [VA_W-1:0]               wrTag,
  input  logic [3:0]                    wrSize,
  input  logic                          wrGlobal,
  input  logic [ASID_W-1:0]             wrAsid,
  input  logic [1:0][PA_W-MIN_OFF-1:0]  wrPfn,
  input  logic [1:0][CATTR_W-1:0]       wrCattr,
  input  logic [1:0]                    wrDirty,
  input  logic [1:0]                    wrValid,
  input  logic [VA_W-1:0]               lkVa,
  input  logic [ASID_W-1:0]             lkAsid,
  output logic                          matchAny,
  output logic                          matchMulti,
  output logic                          selValid,
  output logic                          selDirty,
  output logic [PA_W-1:0]               rspPa,
  output logic [CATTR_W-1:0]            rspCattr
);
  localparam int PFN_W = PA_W - MIN_OFF;

  logic [ENTRIES-1:0]                usedQ;
  logic [VA_W-1:0]                   tagQ   [ENTRIES];
  logic [3:0]                        sizeQ  [ENTRIES];
  logic                              globQ  [ENTRIES];
  logic [ASID_W-1:0]                 asidQ  [ENTRIES];
  logic [1:0][PFN_W-1:0]             pfnQ   [ENTRIES];
  logic [1:0][CATTR_W-1:0]           cattrQ [ENTRIES];
  logic [1:0]                        dirtyQ [ENTRIES];
  logic [1:0]                        validQ [ENTRIES];

  logic [3:0]        wrSizeC;
  logic [PFN_W-1:0]  pfnKeep;
  logic [VA_W-1:0]   tagKeep;

  assign wrSizeC = clampSize(wrSize);
  assign pfnKeep = ~PFN_W'(lowMask(wrSizeC, 0) >> MIN_OFF);
  assign tagKeep = ~VA_W'(lowMask(wrSizeC, 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usedQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.wrEn && strobe.wrIdx == MAX_IDX_W'(i)) usedQ[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (strobe.wrEn && strobe.wrIdx == MAX_IDX_W'(i)) begin
        tagQ[i]   <= wrTag & tagKeep;
        sizeQ[i]  <= wrSizeC;
        globQ[i]  <= wrGlobal;
        asidQ[i]  <= wrAsid;
        for (int f = 0; f < 2; f++) begin
          pfnQ[i][f]   <= wrPfn[f] & pfnKeep;
          cattrQ[i][f] <= wrCattr[f];
          dirtyQ[i][f] <= wrDirty[f];
          validQ[i][f] <= wrValid[f];
        end
      end
    end
  end

  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] oddE;
  logic [ENTRIES-1:0] dirtyE;
  logic [ENTRIES-1:0] validE;
  logic [PA_W-1:0]    paE    [ENTRIES];
  logic [CATTR_W-1:0] cattrE [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : gEnt
    logic [63:0] offM;
    logic [63:0] cmpM;
    logic [63:0] vaX;
    assign offM      = lowMask(sizeQ[i], 0);
    assign cmpM      = ~lowMask(sizeQ[i], 1);
    assign vaX       = 64'(lkVa);
    assign hitVec[i] = usedQ[i]
                       && (((vaX ^ 64'(tagQ[i])) & cmpM) == 64'd0)
                       && (globQ[i] || asidQ[i] == lkAsid);
    assign oddE[i]   = |(vaX & (offM + 64'd1));
    assign paE[i]    = {pfnQ[i][oddE[i]], {MIN_OFF{1'b0}}} | PA_W'(vaX & offM);
    assign cattrE[i] = cattrQ[i][oddE[i]];
    assign dirtyE[i] = dirtyQ[i][oddE[i]];
    assign validE[i] = validQ[i][oddE[i]];
  end

  logic [PA_W-1:0]    paSel;
  logic [CATTR_W-1:0] cattrSel;

  always_comb begin
    paSel    = '0;
    cattrSel = '0;
    selValid = 1'b0;
    selDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) begin
        paSel    = paSel | paE[i];
        cattrSel = cattrSel | cattrE[i];
        selValid = selValid | validE[i];
        selDirty = selDirty | dirtyE[i];
      end
    end
  end

  assign matchAny   = |hitVec;
  assign matchMulti = |(hitVec & (hitVec - ENTRIES'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspPa    <= '0;
      rspCattr <= '0;
    end else if (strobe.latchXlate) begin
      rspPa    <= paSel;
      rspCattr <= cattrSel;
    end else begin
      rspPa    <= '0;
      rspCattr <= '0;
    end
  end
endmodule

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import pairTlbPkg::*;
#(
  parameter int ENTRIES = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [MAX_IDX_W-1:0] wrIdx,
  input  logic                 lkValid,
  input  logic [1:0]           lkAccess,
  input  logic                 lkInHandler,
  input  logic                 matchAny,
  input  logic                 matchMulti,
  input  logic                 selValid,
  input  logic                 selDirty,
  output tlbStrobe_t           strobe,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic [2:0]           rspExc,
  output logic                 rspMultiHit
);
  excCode_t baseExc;
  excCode_t finalExc;
  logic     hitNow;
  logic     multiNow;

  always_comb begin
    if (!matchAny)                                             baseExc = EXC_REFILL;
    else if (matchMulti)                                       baseExc = EXC_NONE;
    else if (!selValid)                                        baseExc = EXC_INVALID;
    else if (access_t'(lkAccess) == ACC_STORE && !selDirty)    baseExc = EXC_MODIFIED;
    else                                                       baseExc = EXC_NONE;
  end

  assign finalExc = (baseExc != EXC_NONE && lkInHandler) ? EXC_DOUBLE : baseExc;
  assign multiNow = matchAny && matchMulti;
  assign hitNow   = lkValid && matchAny && !matchMulti && baseExc == EXC_NONE;

  assign strobe.wrEn       = wrEn && (int'(wrIdx) < ENTRIES);
  assign strobe.wrIdx      = wrIdx;
  assign strobe.latchXlate = hitNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspExc      <= 3'd0;
      rspMultiHit <= 1'b0;
    end else begin
      rspValid    <= lkValid;
      rspHit      <= hitNow;
      rspExc      <= lkValid ? finalExc : EXC_NONE;
      rspMultiHit <= lkValid && multiNow;
    end
  end
endmodule

// File: rtl/pairTlb.sv
module pairTlb
  import pairTlbPkg::*;
#(
  parameter int ENTRIES = 12,
  parameter int VA_W    = 32,
  parameter int PA_W    = 36,
  parameter int ASID_W  = 8,
  parameter int CATTR_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [MAX_IDX_W-1:0]    wrIdx,
  input  logic [VA_W-1:0]         wrTag,
  input  logic [3:0]              wrSize,
  input  logic                    wrGlobal,
  input  logic [ASID_W-1:0]       wrAsid,
  input  logic [PA_W-MIN_OFF-1:0] wrPfn0,
  input  logic [CATTR_W-1:0]      wrCattr0,
  input  logic                    wrDirty0,
  input  logic                    wrValid0,
  input  logic [PA_W-MIN_OFF-1:0] wrPfn1,
  input  logic [CATTR_W-1:0]      wrCattr1,
  input  logic                    wrDirty1,
  input  logic                    wrValid1,
  input  logic                    lkValid,
  input  logic [VA_W-1:0]         lkVa,
  input  logic [ASID_W-1:0]       lkAsid,
  input  logic [1:0]              lkAccess,
  input  logic                    lkInHandler,
  output logic                    rspValid,
  output logic                    rspHit,
  output logic [PA_W-1:0]         rspPa,
  output logic [CATTR_W-1:0]      rspCattr,
  output logic [2:0]              rspExc,
  output logic                    rspMultiHit
);
  tlbStrobe_t strobe;
  logic matchAny, matchMulti, selValid, selDirty;

  tlbCtrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx),
    .lkValid(lkValid), .lkAccess(lkAccess), .lkInHandler(lkInHandler),
    .matchAny(matchAny), .matchMulti(matchMulti),
    .selValid(selValid), .selDirty(selDirty), .strobe(strobe),
    .rspValid(rspValid), .rspHit(rspHit), .rspExc(rspExc),
    .rspMultiHit(rspMultiHit)
  );

  tlbData #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W),
    .ASID_W(ASID_W), .CATTR_W(CATTR_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrTag(wrTag), .wrSize(wrSize), .wrGlobal(wrGlobal), .wrAsid(wrAsid),
    .wrPfn({wrPfn1, wrPfn0}), .wrCattr({wrCattr1, wrCattr0}),
    .wrDirty({wrDirty1, wrDirty0}), .wrValid({wrValid1, wrValid0}),
    .lkVa(lkVa), .lkAsid(lkAsid),
    .matchAny(matchAny), .matchMulti(matchMulti),
    .selValid(selValid), .selDirty(selDirty),
    .rspPa(rspPa), .rspCattr(rspCattr)
  );
endmodule

// File: rtl/pairTlbChk.sv
module pairTlbChk #(
  parameter int VA_W = 32,
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic [VA_W-1:0] lkVa,
  input logic [1:0]      lkAccess,
  input logic            lkInHandler,
  input logic            rspValid,
  input logic            rspHit,
  input logic [PA_W-1:0] rspPa,
  input logic [2:0]      rspExc,
  input logic            rspMultiHit
);
  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);
  p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspHit && rspExc == 3'd0 && !rspMultiHit && rspPa == '0));
  p_hit_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspExc == 3'd0 && !rspMultiHit));
  p_multi_no_xlate_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspMultiHit |-> (!rspHit && rspExc == 3'd0 && rspPa == '0));
  p_code_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspExc <= 3'd4);
  p_double_needs_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkInHandler) |=> rspExc != 3'd4);
  p_flag_masks_codes_r10: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkInHandler) |=> (rspExc == 3'd0 || rspExc == 3'd4));
  p_modified_store_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkAccess != 2'd1) |=> rspExc != 3'd3);
  p_offset_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspPa[9:0] == $past(lkVa[9:0]));
endmodule

bind pairTlb pairTlbChk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVa(lkVa),
  .lkAccess(lkAccess), .lkInHandler(lkInHandler), .rspValid(rspValid),
  .rspHit(rspHit), .rspPa(rspPa), .rspExc(rspExc), .rspMultiHit(rspMultiHit)
);

// File: tb/pairTlb_tb.sv
module pairTlb_tb;
  localparam int NENT = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 0;
  logic [5:0]  wrIdx = 0;
  logic [31:0] wrTag = 0;
  logic [3:0]  wrSize = 0;
  logic        wrGlobal = 0;
  logic [7:0]  wrAsid = 0;
  logic [25:0] wrPfn0 = 0, wrPfn1 = 0;
  logic [2:0]  wrCattr0 = 0, wrCattr1 = 0;
  logic        wrDirty0 = 0, wrDirty1 = 0, wrValid0 = 0, wrValid1 = 0;
  logic        lkValid = 0;
  logic [31:0] lkVa = 0;
  logic [7:0]  lkAsid = 0;
  logic [1:0]  lkAccess = 0;
  logic        lkInHandler = 0;
  logic        rspValid, rspHit, rspMultiHit;
  logic [35:0] rspPa;
  logic [2:0]  rspCattr, rspExc;

  pairTlb u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrTag(wrTag),
    .wrSize(wrSize), .wrGlobal(wrGlobal), .wrAsid(wrAsid),
    .wrPfn0(wrPfn0), .wrCattr0(wrCattr0), .wrDirty0(wrDirty0), .wrValid0(wrValid0),
    .wrPfn1(wrPfn1), .wrCattr1(wrCattr1), .wrDirty1(wrDirty1), .wrValid1(wrValid1),
    .lkValid(lkValid), .lkVa(lkVa), .lkAsid(lkAsid), .lkAccess(lkAccess),
    .lkInHandler(lkInHandler), .rspValid(rspValid), .rspHit(rspHit),
    .rspPa(rspPa), .rspCattr(rspCattr), .rspExc(rspExc), .rspMultiHit(rspMultiHit)
  );

  always #10 clk = ~clk;  // 20 ns period

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // behavioural model: raw written values, interpreted at lookup time
  bit          mUsed  [NENT];
  logic [31:0] mTag   [NENT];
  int          mSize  [NENT];
  bit          mGlob  [NENT];
  logic [7:0]  mAsid  [NENT];
  logic [25:0] mPfn   [NENT][2];
  logic [2:0]  mCattr [NENT][2];
  bit          mDirty [NENT][2];
  bit          mValid [NENT][2];

  bit          eValid, eHit, eMulti;
  logic [35:0] ePa;
  logic [2:0]  eCattr, eExc;

  task automatic chk(input string req, input string name,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h (va=%h)", req, name, act, exp, lkVa);
    end
  endtask

  task automatic computeExp();
    int nHit, hi, c, sb;
    bit odd;
    eValid = lkValid; eHit = 0; eMulti = 0; ePa = 0; eCattr = 0; eExc = 0;
    if (lkValid) begin
      nHit = 0; hi = 0;
      for (int i = 0; i < NENT; i++) begin
        if (mUsed[i]) begin
          c  = (mSize[i] > 9) ? 9 : mSize[i];
          sb = 10 + 2 * c;
          if ((lkVa >> (sb + 1)) == (mTag[i] >> (sb + 1)) &&
              (mGlob[i] || mAsid[i] == lkAsid)) begin
            nHit++; hi = i;
          end
        end
      end
      if (nHit == 0) eExc = 1;
      else if (nHit > 1) eMulti = 1;
      else begin
        c   = (mSize[hi] > 9) ? 9 : mSize[hi];
        sb  = 10 + 2 * c;
        odd = lkVa[sb];
        if (!mValid[hi][odd]) eExc = 2;
        else if (lkAccess == 2'd1 && !mDirty[hi][odd]) eExc = 3;
        else begin
          eHit   = 1;
          ePa    = (36'(mPfn[hi][odd] >> (2 * c)) << sb) |
                   36'(lkVa & ((32'd1 << sb) - 32'd1));
          eCattr = mCattr[hi][odd];
        end
      end
      if (eExc != 0 && lkInHandler) eExc = 4;
    end
  endtask

  task automatic modelWrite();
    if (wrEn && int'(wrIdx) < NENT) begin
      mUsed[wrIdx] = 1; mTag[wrIdx] = wrTag; mSize[wrIdx] = int'(wrSize);
      mGlob[wrIdx] = wrGlobal; mAsid[wrIdx] = wrAsid;
      mPfn[wrIdx][0] = wrPfn0; mCattr[wrIdx][0] = wrCattr0;
      mDirty[wrIdx][0] = wrDirty0; mValid[wrIdx][0] = wrValid0;
      mPfn[wrIdx][1] = wrPfn1; mCattr[wrIdx][1] = wrCattr1;
      mDirty[wrIdx][1] = wrDirty1; mValid[wrIdx][1] = wrValid1;
    end
  endtask

  // inputs already set at a falling edge; run one clock and compare
  task automatic tick(input string req);
    computeExp();
    modelWrite();
    @(posedge clk);
    @(negedge clk);
    chk(req, "rspValid", 64'(rspValid), 64'(eValid));
    chk(req, "rspHit", 64'(rspHit), 64'(eHit));
    chk(req, "rspExc", 64'(rspExc), 64'(eExc));
    chk(req, "rspMultiHit", 64'(rspMultiHit), 64'(eMulti));
    chk(req, "rspPa", 64'(rspPa), 64'(ePa));
    chk(req, "rspCattr", 64'(rspCattr), 64'(eCattr));
    wrEn = 0; lkValid = 0; lkInHandler = 0;
  endtask

  task automatic wrEntry(input int idx, input logic [31:0] va, input int size,
                         input bit g, input logic [7:0] asid,
                         input logic [25:0] p0, input logic [2:0] c0, input bit d0, input bit v0,
                         input logic [25:0] p1, input logic [2:0] c1, input bit d1, input bit v1,
                         input string req);
    wrEn = 1; wrIdx = 6'(idx); wrTag = va; wrSize = 4'(size); wrGlobal = g; wrAsid = asid;
    wrPfn0 = p0; wrCattr0 = c0; wrDirty0 = d0; wrValid0 = v0;
    wrPfn1 = p1; wrCattr1 = c1; wrDirty1 = d1; wrValid1 = v1;
    tick(req);
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid,
                      input logic [1:0] acc, input bit ih, input string req);
    lkValid = 1; lkVa = va; lkAsid = asid; lkAccess = acc; lkInHandler = ih;
    tick(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) mUsed[i] = 0;
    repeat (3) @(negedge clk);
    // reset state before release (R2)
    chk("R2", "rspValid at reset", 64'(rspValid), 64'd0);
    chk("R2", "rspPa at reset", 64'(rspPa), 64'd0);
    rstN = 1;
    @(negedge clk);

    look(32'h1234_5678, 8'd1, 2'd0, 0, "R1");
    look(32'h1234_5678, 8'd1, 2'd2, 1, "R1_R10");
    tick("R2");

    // 16 KB pages, pair spans 32 KB at 0x0040_0000, asid 5
    wrEntry(0, 32'h0040_0000, 2, 0, 8'd5,
            26'h12345, 3'd2, 1, 1, 26'h0ABCD, 3'd5, 0, 1, "R12");
    look(32'h0040_1234, 8'd5, 2'd0, 0, "R5");   // even frame
    look(32'h0040_5234, 8'd5, 2'd0, 0, "R5");   // odd frame, bit 14 set
    look(32'h0040_5234, 8'd5, 2'd1, 0, "R9");   // store to clean frame -> 3
    look(32'h0040_5234, 8'd5, 2'd2, 0, "R9");   // fetch hits
    look(32'h0040_1234, 8'd5, 2'd1, 0, "R6");   // store to dirty frame
    look(32'h0040_1234, 8'd6, 2'd0, 0, "R4");   // wrong asid -> refill
    look(32'h0040_8000, 8'd5, 2'd0, 0, "R3");   // outside pair
    look(32'h0040_7FFF, 8'd5, 2'd0, 0, "R3");   // top of pair
    look(32'h0040_5234, 8'd5, 2'd1, 1, "R10");  // modified -> double

    // 256 MB pages, global, frame 0 invalid
    wrEntry(1, 32'hC000_0000, 9, 1, 8'd0,
            26'h1FF_FFFF, 3'd1, 1, 0, 26'h2A5_5555, 3'd6, 1, 1, "R12");
    look(32'hC123_4567, 8'd9, 2'd0, 0, "R8");
    look(32'hC123_4567, 8'd9, 2'd2, 0, "R8");
    look(32'hD123_4567, 8'd9, 2'd0, 0, "R6");
    look(32'hD123_4567, 8'd200, 2'd1, 0, "R4");
    look(32'hC123_4567, 8'd9, 2'd1, 1, "R10");
    look(32'hD123_4567, 8'd9, 2'd0, 1, "R10");  // hit unaffected by flag

    // size code 15 acts as 9
    wrEntry(2, 32'h2000_0000, 15, 1, 8'd0,
            26'h0001234, 3'd3, 1, 1, 26'h3C0_0000, 3'd4, 1, 1, "R3");
    look(32'h3000_0010, 8'd1, 2'd0, 0, "R3");
    look(32'h2FFF_FFF0, 8'd1, 2'd0, 0, "R3");

    // 1 KB pages
    wrEntry(3, 32'h0000_0C00, 0, 0, 8'd7,
            26'h0000111, 3'd1, 1, 1, 26'h0000222, 3'd2, 1, 1, "R12");
    look(32'h0000_0834, 8'd7, 2'd0, 0, "R5");
    look(32'h0000_0C34, 8'd7, 2'd0, 0, "R5");
    look(32'h0000_1000, 8'd7, 2'd0, 0, "R7");

    // overlap with entry 0 for asid 5
    wrEntry(4, 32'h0040_1000, 0, 1, 8'd0,
            26'h0000333, 3'd7, 1, 1, 26'h0000444, 3'd0, 1, 1, "R12");
    look(32'h0040_1234, 8'd5, 2'd0, 0, "R11");
    look(32'h0040_1234, 8'd6, 2'd0, 0, "R11");
    wrEntry(4, 32'h0800_0000, 0, 1, 8'd0,
            26'h0000333, 3'd7, 1, 1, 26'h0000444, 3'd0, 1, 1, "R12");
    look(32'h0040_1234, 8'd5, 2'd0, 0, "R12");

    // out-of-range index ignored; last index works
    wrEntry(13, 32'h5000_0000, 4, 1, 8'd0,
            26'h00ABCDE, 3'd1, 1, 1, 26'h00ABCDE, 3'd1, 1, 1, "R12");
    look(32'h5000_0000, 8'd0, 2'd0, 0, "R12");
    wrEntry(11, 32'h5000_0000, 4, 1, 8'd0,
            26'h00ABCDE, 3'd1, 1, 1, 26'h00ABCDF, 3'd2, 1, 1, "R12");
    look(32'h5000_0000, 8'd0, 2'd0, 0, "R12");

    // write and lookup in the same cycle
    wrEn = 1; wrIdx = 6'd5; wrTag = 32'h6000_0000; wrSize = 4'd1; wrGlobal = 1;
    wrAsid = 0; wrPfn0 = 26'h0055555; wrCattr0 = 3'd3; wrDirty0 = 1; wrValid0 = 1;
    wrPfn1 = 26'h0066666; wrCattr1 = 3'd4; wrDirty1 = 1; wrValid1 = 1;
    lkValid = 1; lkVa = 32'h6000_0100; lkAsid = 0; lkAccess = 0;
    tick("R12");
    look(32'h6000_0100, 8'd0, 2'd0, 0, "R12");

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] base;
      case ($urandom % 6)
        0: base = 32'h0040_0000;
        1: base = 32'hC000_0000;
        2: base = 32'h2000_0000;
        3: base = 32'h0000_0800;
        4: base = 32'h6000_0000;
        default: base = $urandom;
      endcase
      if ($urandom % 8 == 0) tick("R2");
      else begin
        logic [7:0] a;
        case ($urandom % 3)
          0: a = 8'd5;
          1: a = 8'd7;
          default: a = 8'd9;
        endcase
        look(base ^ ($urandom & 32'h1FFF_FFFF >> ($urandom % 20)), a,
             2'($urandom % 3), ($urandom % 10) == 0, "R3");
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule